// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the host-facing access point for a chip's configuration space. The host sees two byte-wide addresses: an index address and a data address. The configuration registers stay hidden until the host writes a key byte to the index address twice in a row. After that, the host writes a register number to the index address and then reads or writes that register through the data address. A single lock byte written to the index address hides the space again.

The register space has two parts. A global part holds a read-only identity (a 16-bit device code, a revision byte and a 16-bit vendor code) and a logical-device selector. A banked part holds one register set per logical device. The selector decides which set appears at the banked indices. Each set has an enable byte, whose bit 0 drives that device's enable output, and a small array of general configuration bytes. All of these bytes are brought out to the device logic.

The block decodes only the index/data selection. Comparing the full I/O base address (for example the usual choices 0x2E or 0x4E) is done upstream, and that logic drives `bus_sel`.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the port is locked (`cfg_open` = 0), `bus_rdata` = 0xFF, `dev_en` = 0, the index is 0x00 and the device selector is 0x00.
- R2: Two index-address writes of the key byte 0x87 in succession open the port. `cfg_open` rises right after the clock edge that samples the second write. A single key write leaves the port closed.
- R3: Any other index-address write that arrives between the two key bytes cancels the sequence, and two fresh key bytes are then needed. Data-address cycles do not disturb the sequence.
- R4: While the port is open, an index write of 0xAA closes it and resets the index to 0x00. Every other index write stores its byte as the index, including 0x87.
- R5: While the port is not open, data-address writes change no register, and every read on either address returns 0xFF.
- R6: A read strobe (`bus_rd`=1) loads `bus_rdata` at that clock edge. The value stays unchanged until the next read strobe.
- R7: Identity registers read index 0x20 = device code high byte, 0x21 = device code low byte, 0x22 = revision, 0x23 = 0x19, 0x24 = 0x34. They are read-only, and data writes to them have no effect.
- R8: Index 0x07 is the device selector and can be read and written. The banked indices (0x30 and BANK_BASE..BANK_BASE+BANK_DEPTH-1, default 0xF0..0xF3) reach only the bank of the selected device, and each device keeps its own values.
- R9: Bit 0 of banked index 0x30 is the selected device's enable and drives `dev_en[selector]`. The other bits of that byte read back as 0.
- R10: Indices that are not implemented read 0x00. When the selector is NUM_LD or higher, banked reads return 0x00 and banked writes change nothing.
- R11: While the port is open, a read on the index address returns the stored index.
- R12: `dev_cfg` bits [(d*BANK_DEPTH+k)*8 +: 8] hold configuration byte k of device d, and they are updated at the edge that samples the data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | 0 = index address, 1 = data address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| cfg_open | output | 1 | Configuration space is reachable |
| dev_en | output | NUM_LD | Per-device enable bits |
| dev_cfg | output | NUM_LD*BANK_DEPTH*8 | Configuration bytes of all devices |

## Verification
Every write, whether to the key sequencer, the index, the selector or a bank, takes effect at the clock edge that samples the strobe. `cfg_open`, `dev_en` and `dev_cfg` therefore change right after that edge. Read data travels through one register and is due one edge after the read strobe, and it then holds. The bench raises each strobe for a single cycle starting at a falling edge. It samples at the next falling edge, which comes after exactly one rising edge and so catches both the write effect and the registered read. Its random phase keeps a model of the key state, index, selector and banks, and compares every read and every `cfg_open` value against that model.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] IDX_LDSEL   = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_VEND_HI = 8'h23;
    localparam logic [7:0] IDX_VEND_LO = 8'h24;
    localparam logic [7:0] IDX_ENABLE  = 8'h30;

endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
#(
    parameter logic [7:0] KEY_BYTE  = 8'h87,
    parameter logic [7:0] LOCK_BYTE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open,
    output logic       idx_load,
    output logic       idx_clear
);

    typedef struct packed {
        key_state_e st;
    } key_s;

    key_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (idx_wr) begin
            case (s_q.st)
                KEY_LOCKED: s_d.st = (wdata == KEY_BYTE) ? KEY_HALF : KEY_LOCKED;
                KEY_HALF:   s_d.st = (wdata == KEY_BYTE) ? KEY_OPEN : KEY_LOCKED;
                KEY_OPEN:   s_d.st = (wdata == LOCK_BYTE) ? KEY_LOCKED : KEY_OPEN;
                default:    s_d.st = KEY_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: KEY_LOCKED};
        else        s_q <= s_d;
    end

    assign open      = (s_q.st == KEY_OPEN);
    assign idx_clear = open && idx_wr && (wdata == LOCK_BYTE);
    assign idx_load  = open && idx_wr && (wdata != LOCK_BYTE);

endmodule

// File: rtl/cfgp_ld_bank.sv
module cfgp_ld_bank
    import cfgp_pkg::*;
#(
    parameter int BANK_DEPTH = 4,
    parameter int BANK_BASE  = 8'hF0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    wr,
    input  logic [7:0]              idx,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output logic                    enable,
    output logic [BANK_DEPTH*8-1:0] cfg_flat
);

    typedef struct packed {
        logic                        en;
        logic [BANK_DEPTH-1:0][7:0]  cfg;
    } bank_s;

    bank_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sel && wr) begin
            if (idx == IDX_ENABLE) s_d.en = wdata[0];
            for (int k = 0; k < BANK_DEPTH; k++) begin
                if (idx == 8'(BANK_BASE + k)) s_d.cfg[k] = wdata;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (idx == IDX_ENABLE) rdata = {7'b0, s_q.en};
        for (int k = 0; k < BANK_DEPTH; k++) begin
            if (idx == 8'(BANK_BASE + k)) rdata = s_q.cfg[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign enable   = s_q.en;
    assign cfg_flat = s_q.cfg;

endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
    import cfgp_pkg::*;
#(
    parameter int          NUM_LD     = 4,
    parameter int          BANK_DEPTH = 4,
    parameter int          BANK_BASE  = 8'hF0,
    parameter logic [15:0] DEV_CODE   = 16'h0901,
    parameter logic [7:0]  DEV_REV    = 8'h3C,
    parameter logic [15:0] VEND_CODE  = 16'h1934,
    parameter logic [7:0]  KEY_BYTE   = 8'h87,
    parameter logic [7:0]  LOCK_BYTE  = 8'hAA
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [7:0]                     bus_wdata,
    output logic [7:0]                     bus_rdata,
    output logic                           cfg_open,
    output logic [NUM_LD-1:0]              dev_en,
    output logic [NUM_LD*BANK_DEPTH*8-1:0] dev_cfg
);

    localparam int BANK_W = BANK_DEPTH * 8;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] ld;
        logic [7:0] rdata;
    } port_s;

    port_s s_d, s_q;

    logic       open;
    logic       idx_load;
    logic       idx_clear;
    logic       idx_wr;
    logic       dat_wr;
    logic [7:0] bank_val;
    logic [7:0] reg_val;
    logic [7:0] bank_rd [NUM_LD];

    assign idx_wr = bus_wr && !bus_sel;
    assign dat_wr = bus_wr && bus_sel && open;

    cfgp_key_fsm #(
        .KEY_BYTE  (KEY_BYTE),
        .LOCK_BYTE (LOCK_BYTE)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .wdata     (bus_wdata),
        .open      (open),
        .idx_load  (idx_load),
        .idx_clear (idx_clear)
    );

    for (genvar g = 0; g < NUM_LD; g++) begin : g_bank
        cfgp_ld_bank #(
            .BANK_DEPTH (BANK_DEPTH),
            .BANK_BASE  (BANK_BASE)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (s_q.ld == 8'(g)),
            .wr       (dat_wr),
            .idx      (s_q.idx),
            .wdata    (bus_wdata),
            .rdata    (bank_rd[g]),
            .enable   (dev_en[g]),
            .cfg_flat (dev_cfg[g*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        bank_val = 8'h00;
        for (int g = 0; g < NUM_LD; g++) begin
            if (s_q.ld == 8'(g)) bank_val = bank_rd[g];
        end
    end

    always_comb begin
        case (s_q.idx)
            IDX_LDSEL:   reg_val = s_q.ld;
            IDX_ID_HI:   reg_val = DEV_CODE[15:8];
            IDX_ID_LO:   reg_val = DEV_CODE[7:0];
            IDX_REV:     reg_val = DEV_REV;
            IDX_VEND_HI: reg_val = VEND_CODE[15:8];
            IDX_VEND_LO: reg_val = VEND_CODE[7:0];
            default:     reg_val = bank_val;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (idx_clear)     s_d.idx = 8'h00;
        else if (idx_load) s_d.idx = bus_wdata;
        if (dat_wr && s_q.idx == IDX_LDSEL) s_d.ld = bus_wdata;
        if (bus_rd) begin
            if (!open)        s_d.rdata = 8'hFF;
            else if (bus_sel) s_d.rdata = reg_val;
            else              s_d.rdata = s_q.idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{idx: 8'h00, ld: 8'h00, rdata: 8'hFF};
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;
    assign cfg_open  = open;

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter int         NUM_LD    = 4,
    parameter logic [7:0] KEY_BYTE  = 8'h87,
    parameter logic [7:0] LOCK_BYTE = 8'hAA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cfg_open,
    input logic [NUM_LD-1:0] dev_en
);

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && !bus_sel && bus_wdata == KEY_BYTE)); // R2

    AST_LOCK_BYTE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && !bus_sel && bus_wdata == LOCK_BYTE) |=> !cfg_open); // R4

    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_rd) |=> (bus_rdata == 8'hFF)); // R5

    AST_LOCKED_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(dev_en)); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R6

endmodule

bind cfg_key_port cfgp_checker #(
    .NUM_LD    (NUM_LD),
    .KEY_BYTE  (KEY_BYTE),
    .LOCK_BYTE (LOCK_BYTE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_open  (cfg_open),
    .dev_en    (dev_en)
);

// File: tb/cfg_key_port_tb_top.sv
`timescale 1ns/1ps
module cfg_key_port_tb_top;

    localparam int NLD = 4;
    localparam int DEP = 4;
    localparam int BB  = 8'hF0;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   bus_sel = 1'b0;
    logic                   bus_wr = 1'b0;
    logic                   bus_rd = 1'b0;
    logic [7:0]             bus_wdata = 8'h00;
    logic [7:0]             bus_rdata;
    logic                   cfg_open;
    logic [NLD-1:0]         dev_en;
    logic [NLD*DEP*8-1:0]   dev_cfg;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cfg_key_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_open  (cfg_open),
        .dev_en    (dev_en),
        .dev_cfg   (dev_cfg)
    );

    // model state built from the requirements
    int         m_st = 0;   // 0 locked, 1 one key seen, 2 open
    logic [7:0] m_idx = 8'h00;
    logic [7:0] m_ld  = 8'h00;
    logic       m_en  [NLD];
    logic [7:0] m_cfg [NLD][DEP];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_data();
        logic [7:0] v;
        if (m_st != 2) return 8'hFF;
        case (m_idx)
            8'h07: v = m_ld;
            8'h20: v = 8'h09;
            8'h21: v = 8'h01;
            8'h22: v = 8'h3C;
            8'h23: v = 8'h19;
            8'h24: v = 8'h34;
            8'h30: v = (m_ld < NLD) ? {7'b0, m_en[m_ld]} : 8'h00;
            default: begin
                v = 8'h00;
                if (m_idx >= 8'(BB) && m_idx < 8'(BB + DEP) && m_ld < NLD)
                    v = m_cfg[m_ld][m_idx - 8'(BB)];
            end
        endcase
        return v;
    endfunction

    function automatic logic [NLD-1:0] exp_en();
        logic [NLD-1:0] v;
        for (int i = 0; i < NLD; i++) v[i] = m_en[i];
        return v;
    endfunction

    function automatic string tag_of(input logic [7:0] idx);
        if (m_st != 2) return "R5";
        if (idx == 8'h07) return "R8";
        if (idx >= 8'h20 && idx <= 8'h24) return "R7";
        if (idx == 8'h30) return (m_ld < NLD) ? "R9" : "R10";
        if (idx >= 8'(BB) && idx < 8'(BB + DEP)) return (m_ld < NLD) ? "R8" : "R10";
        return "R10";
    endfunction

    task automatic cycle(input logic sel, input logic wr, input logic rd, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr_idx(input logic [7:0] v);
        cycle(1'b0, 1'b1, 1'b0, v);
        case (m_st)
            0: m_st = (v == 8'h87) ? 1 : 0;
            1: m_st = (v == 8'h87) ? 2 : 0;
            default: begin
                if (v == 8'hAA) begin m_st = 0; m_idx = 8'h00; end
                else m_idx = v;
            end
        endcase
    endtask

    task automatic wr_dat(input logic [7:0] v);
        cycle(1'b1, 1'b1, 1'b0, v);
        if (m_st == 2) begin
            if (m_idx == 8'h07) m_ld = v;
            else if (m_idx == 8'h30 && m_ld < NLD) m_en[m_ld] = v[0];
            else if (m_idx >= 8'(BB) && m_idx < 8'(BB + DEP) && m_ld < NLD)
                m_cfg[m_ld][m_idx - 8'(BB)] = v;
        end
    endtask

    task automatic rd_dat(output logic [7:0] v);
        cycle(1'b1, 1'b0, 1'b1, 8'h00);
        v = bus_rdata;
    endtask

    task automatic rd_idx(output logic [7:0] v);
        cycle(1'b0, 1'b0, 1'b1, 8'h00);
        v = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r, hold;
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < NLD; i++) begin
            m_en[i] = 1'b0;
            for (int k = 0; k < DEP; k++) m_cfg[i][k] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", bus_rdata, 8'hFF);
        chk("R1 open", cfg_open, 0);
        chk("R1 dev_en", dev_en, 0);

        // R2 single key then second key
        wr_idx(8'h87);
        chk("R2 one key", cfg_open, 0);
        rd_dat(r);
        chk("R5 read while half", r, 8'hFF);
        wr_idx(8'h87);
        chk("R2 two keys", cfg_open, 1);
        rd_idx(r);
        chk("R1 index reset", r, 8'h00);

        // R4 lock byte
        wr_idx(8'hAA);
        chk("R4 lock", cfg_open, 0);

        // R3 interrupted sequence
        wr_idx(8'h87); wr_idx(8'h20); wr_idx(8'h87);
        chk("R3 interrupted", cfg_open, 0);
        wr_idx(8'h87);
        chk("R3 fresh pair", cfg_open, 1);

        // R7 identity
        wr_idx(8'h20); rd_dat(r); chk("R7 id hi", r, 8'h09);
        wr_idx(8'h21); rd_dat(r); chk("R7 id lo", r, 8'h01);
        wr_idx(8'h22); rd_dat(r); chk("R7 rev", r, 8'h3C);
        wr_idx(8'h23); rd_dat(r); chk("R7 vend hi", r, 8'h19);
        wr_idx(8'h24); rd_dat(r); chk("R7 vend lo", r, 8'h34);
        wr_idx(8'h23); wr_dat(8'h55); rd_dat(r); chk("R7 read-only", r, 8'h19);

        // R11 index readback, R4 key byte latched as index while open
        wr_idx(8'h87); rd_idx(r); chk("R4 key as index", r, 8'h87);
        chk("R4 still open", cfg_open, 1);
        wr_idx(8'h30); rd_idx(r); chk("R11 index read", r, 8'h30);

        // R8 / R9 / R12
        wr_idx(8'h07); wr_dat(8'h02); rd_dat(r); chk("R8 selector", r, 8'h02);
        wr_idx(8'h30); wr_dat(8'hFF); rd_dat(r); chk("R9 enable bits", r, 8'h01);
        chk("R9 dev_en", dev_en, 4'b0100);
        wr_idx(8'hF1); wr_dat(8'hA5); rd_dat(r); chk("R8 bank write", r, 8'hA5);
        chk("R12 dev_cfg", dev_cfg[(2*DEP+1)*8 +: 8], 8'hA5);
        wr_idx(8'h07); wr_dat(8'h01);
        wr_idx(8'hF1); rd_dat(r); chk("R8 separate bank", r, 8'h00);

        // R6 hold
        hold = r;
        repeat (3) @(negedge clk);
        wr_dat(8'h3E);
        chk("R6 hold", bus_rdata, hold);

        // R10 out-of-range selector and unimplemented index
        wr_idx(8'h07); wr_dat(8'h09);
        wr_idx(8'h30); wr_dat(8'h01); rd_dat(r);
        chk("R10 bank absent", r, 8'h00);
        chk("R10 dev_en", dev_en, 4'b0100);
        wr_idx(8'h50); rd_dat(r); chk("R10 unimplemented", r, 8'h00);

        // R5 locked writes and reads
        wr_idx(8'h07); wr_dat(8'h00); wr_idx(8'h30);
        wr_idx(8'hAA);
        wr_dat(8'h01);
        chk("R5 dev_en locked", dev_en, 4'b0100);
        rd_dat(r); chk("R5 data read", r, 8'hFF);
        rd_idx(r); chk("R5 index read", r, 8'hFF);
        wr_idx(8'h87); wr_idx(8'h87);
        rd_idx(r); chk("R4 index cleared", r, 8'h00);
        wr_idx(8'h30); rd_dat(r); chk("R5 no write", r, 8'h00);

        // constrained random phase against the model
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] v;
            op = $urandom_range(0, 9);
            if (op <= 2) begin
                case ($urandom_range(0, 11))
                    0, 1, 2: v = 8'h87;
                    3:       v = 8'hAA;
                    4, 5:    v = 8'h07;
                    6:       v = 8'h20 + 8'($urandom_range(0, 4));
                    7, 8:    v = 8'h30;
                    9, 10:   v = 8'(BB) + 8'($urandom_range(0, DEP - 1));
                    default: v = 8'($urandom_range(0, 255));
                endcase
                wr_idx(v);
                chk((m_st == 2) ? "R2" : "R3", cfg_open, (m_st == 2) ? 1 : 0);
            end else if (op <= 5) begin
                v = (m_idx == 8'h07) ? 8'($urandom_range(0, NLD + 1)) : 8'($urandom_range(0, 255));
                wr_dat(v);
                chk("R9", dev_en, exp_en());
            end else if (op <= 8) begin
                logic [7:0] e;
                string t;
                e = exp_data();
                t = tag_of(m_idx);
                rd_dat(r);
                chk(t, r, e);
            end else begin
                rd_idx(r);
                chk((m_st == 2) ? "R11" : "R5", r, (m_st == 2) ? m_idx : 8'hFF);
            end
        end

        for (int d = 0; d < NLD; d++) begin
            for (int k = 0; k < DEP; k++) begin
                chk("R12", dev_cfg[(d*DEP+k)*8 +: 8], m_cfg[d][k]);
            end
        end

        finish_run();
    end

endmodule